// File: doc/BRIEF.md
# Shared Byte Buffer with Watermark Interrupts

This block is a 64-entry, 8-bit-wide first-in first-out buffer shared by a host register port and an internal command engine. Only one physical store exists. A select input names the side that currently owns the buffer, and only that side's push and pop strobes take effect. A pop presents the oldest byte on a shared read-data output during the cycle of the strobe. The byte leaves the buffer at the clock edge that ends that cycle.

The block reports how many bytes it holds. It raises two watermark flags against one programmable water level: a near-full flag and a near-empty flag. A push into a full buffer is dropped and sets a sticky overflow flag. Only a flush clears that flag. A flush empties the buffer at once.

A rising edge on either watermark flag, when its enable is set, latches a pending bit. The interrupt output is the OR of the pending bits. The host clears a pending bit by writing a one to its acknowledge input.

Top module: `shared_fifo_alert`

## Requirements
- R1: A push accepted by a non-full buffer stores the byte and raises `level` by one at the next clock edge. `level` always equals the number of bytes held, from 0 to 64.
- R2: While the buffer is not empty, `rd_data` shows the oldest stored byte. A pop removes that byte at the clock edge, so bytes leave in the order they were pushed.
- R3: A push while the buffer holds 64 bytes is discarded, and stored data and `level` are unchanged. `ovfl_err` goes to 1 at that edge and stays 1 until a flush.
- R4: While the buffer is empty, `rd_data` reads 0x00. A pop while empty leaves `level` at 0.
- R5: `flush` sets `level` to 0 and clears `ovfl_err` at the next edge. It takes precedence over any push or pop in the same cycle.
- R6: `hi_alert` is 1 exactly when 64 minus `level` is at most `water`.
- R7: `lo_alert` is 1 exactly when `level` is at most `water`.
- R8: When `irq_en[k]` is 1 and alert k changes from 0 to 1, `irq_pend[k]` becomes 1 one clock edge after the edge that changed `level`. Index 0 is the near-empty alert and index 1 is the near-full alert. `irq` is the OR of `irq_pend`. With the enable at 0, no pending bit is set.
- R9: A 1 on `irq_ack[k]` clears `irq_pend[k]` at the next edge. A new rising edge in the same cycle wins over the acknowledge.
- R10: When `eng_active` is 1, only `eng_wr`/`eng_rd` act on the buffer. When it is 0, only `host_wr`/`host_rd` act. Strobes from the other side have no effect.
- R11: A push and a pop in the same cycle both take effect when the buffer is neither empty nor full, leaving `level` unchanged. When empty, only the push takes effect. When full, only the pop takes effect, and the push counts as an overflow.
- R12: Reset empties the buffer, clears `ovfl_err` and `irq_pend`, and treats both alerts as already high, so the alert levels present after reset raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_active | input | 1 | 1: engine owns the buffer, 0: host owns it |
| host_wr | input | 1 | Host push strobe |
| host_rd | input | 1 | Host pop strobe |
| host_wdata | input | 8 | Host push data |
| eng_wr | input | 1 | Engine push strobe |
| eng_rd | input | 1 | Engine pop strobe |
| eng_wdata | input | 8 | Engine push data |
| flush | input | 1 | Empty the buffer and clear the overflow flag |
| water | input | 7 | Water level for both alerts |
| irq_en | input | 2 | Interrupt enables (bit 0 near-empty, bit 1 near-full) |
| irq_ack | input | 2 | Write-one-to-clear acknowledge for the pending bits |
| rd_data | output | 8 | Oldest stored byte, 0x00 when empty |
| level | output | 7 | Number of bytes held |
| hi_alert | output | 1 | Near-full flag |
| lo_alert | output | 1 | Near-empty flag |
| ovfl_err | output | 1 | Sticky overflow flag |
| irq_pend | output | 2 | Pending interrupt bits |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a rising watermark edge in exactly the cycle where the host acknowledges the same pending bit. To reach it, the stimulus first fills the buffer to one byte below the near-full threshold. It then pushes one more byte and holds the acknowledge high across the following edge, which is the edge that latches the new pending bit. Each watermark is also swept over every water level from 0 to 64. For each level the bench fills the buffer to capacity, forces one overflow and drains it again, checking both flags and the byte order at every step.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    parameter int unsigned DEPTH = 64;
    parameter int unsigned WIDTH = 8;
    parameter int unsigned NALERT = 2;

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    localparam int unsigned AL_LO = 0;
    localparam int unsigned AL_HI = 1;

    typedef logic [WIDTH-1:0] byte_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NALERT-1:0] alert_vec_t;

    localparam lvl_t DEPTH_L = lvl_t'(DEPTH);

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_ENG  = 1'b1
    } side_e;

    typedef struct packed {
        logic  push;
        logic  pop;
        byte_t wdata;
    } port_req_t;

    function automatic logic near_full(input lvl_t lvl, input lvl_t wl);
        return (DEPTH_L - lvl) <= wl;
    endfunction

    function automatic logic near_empty(input lvl_t lvl, input lvl_t wl);
        return lvl <= wl;
    endfunction
endpackage

// File: rtl/sfifo_port_sel.sv
module sfifo_port_sel
    import sfifo_pkg::*;
(
    input  side_e     side,
    input  port_req_t host_req,
    input  port_req_t eng_req,
    output port_req_t sel_req
);
    always_comb begin
        unique case (side)
            SIDE_ENG: sel_req = eng_req;
            default:  sel_req = host_req;
        endcase
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req,
    input  logic      flush,
    output byte_t     rd_data,
    output lvl_t      level,
    output logic      push_drop
);
    lvl_t  wptr, rptr;
    byte_t mem [DEPTH];
    logic  full, empty, do_push, do_pop;

    assign level     = wptr - rptr;
    assign full      = (level == DEPTH_L);
    assign empty     = (level == '0);
    assign do_push   = req.push && !full && !flush;
    assign do_pop    = req.pop && !empty && !flush;
    assign push_drop = req.push && full && !flush;
    assign rd_data   = empty ? '0 : mem[rptr[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + lvl_t'(1);
            if (do_pop)  rptr <= rptr + lvl_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr[PTR_W-1:0]] <= req.wdata;
    end

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_L);

    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0));

    // R4
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && req.pop && !req.push && !flush) |=> (level == '0));

    // R11
    pushpop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !full && req.push && req.pop && !flush) |=> $stable(level));
endmodule

// File: rtl/sfifo_status.sv
module sfifo_status
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t level,
    input  lvl_t water,
    input  logic flush,
    input  logic push_drop,
    output logic hi_alert,
    output logic lo_alert,
    output logic ovfl
);
    assign hi_alert = near_full(level, water);
    assign lo_alert = near_empty(level, water);

    always_ff @(posedge clk) begin
        if (rst || flush) ovfl <= 1'b0;
        else if (push_drop) ovfl <= 1'b1;
    end

    // R3
    ovfl_set_chk: assert property (@(posedge clk) disable iff (rst)
        push_drop |=> ovfl);

    // R3
    ovfl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovfl && !flush) |=> ovfl);
endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  alert_vec_t alert,
    input  alert_vec_t en,
    input  alert_vec_t ack,
    output alert_vec_t pend,
    output logic       irq
);
    alert_vec_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= alert;
    end

    for (genvar k = 0; k < NALERT; k++) begin : g_src
        logic edge_hit;
        assign edge_hit = en[k] && alert[k] && !prev[k];

        always_ff @(posedge clk) begin
            if (rst) pend[k] <= 1'b0;
            else     pend[k] <= edge_hit || (pend[k] && !ack[k]);
        end

        // R8
        rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
            (en[k] && $rose(alert[k])) |=> pend[k]);

        // R9
        ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (ack[k] && !(en[k] && $rose(alert[k]))) |=> !pend[k]);
    end

    assign irq = |pend;
endmodule

// File: rtl/shared_fifo_alert.sv
module shared_fifo_alert
    import sfifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                eng_active,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [WIDTH-1:0]    host_wdata,
    input  logic                eng_wr,
    input  logic                eng_rd,
    input  logic [WIDTH-1:0]    eng_wdata,
    input  logic                flush,
    input  logic [LVL_W-1:0]    water,
    input  logic [NALERT-1:0]   irq_en,
    input  logic [NALERT-1:0]   irq_ack,
    output logic [WIDTH-1:0]    rd_data,
    output logic [LVL_W-1:0]    level,
    output logic                hi_alert,
    output logic                lo_alert,
    output logic                ovfl_err,
    output logic [NALERT-1:0]   irq_pend,
    output logic                irq
);
    port_req_t  host_req, eng_req, sel_req;
    side_e      side;
    logic       push_drop;
    alert_vec_t alerts;

    assign host_req = '{push: host_wr, pop: host_rd, wdata: host_wdata};
    assign eng_req  = '{push: eng_wr,  pop: eng_rd,  wdata: eng_wdata};
    assign side     = eng_active ? SIDE_ENG : SIDE_HOST;

    sfifo_port_sel u_sel (
        .side     (side),
        .host_req (host_req),
        .eng_req  (eng_req),
        .sel_req  (sel_req)
    );

    sfifo_store u_store (
        .clk       (clk),
        .rst       (rst),
        .req       (sel_req),
        .flush     (flush),
        .rd_data   (rd_data),
        .level     (level),
        .push_drop (push_drop)
    );

    sfifo_status u_status (
        .clk       (clk),
        .rst       (rst),
        .level     (level),
        .water     (water),
        .flush     (flush),
        .push_drop (push_drop),
        .hi_alert  (hi_alert),
        .lo_alert  (lo_alert),
        .ovfl      (ovfl_err)
    );

    assign alerts[AL_LO] = lo_alert;
    assign alerts[AL_HI] = hi_alert;

    sfifo_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .alert (alerts),
        .en    (irq_en),
        .ack   (irq_ack),
        .pend  (irq_pend),
        .irq   (irq)
    );

    // R10
    idle_side_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && !sel_req.push && !sel_req.pop) |=> $stable(level));
endmodule

// File: tb/tb_shared_fifo_alert.sv
module tb_shared_fifo_alert;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eng_active = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       eng_wr = 1'b0, eng_rd = 1'b0;
    logic [7:0] eng_wdata = '0;
    logic       flush = 1'b0;
    logic [6:0] water = 7'd4;
    logic [1:0] irq_en = 2'b11;
    logic [1:0] irq_ack = 2'b00;
    logic [7:0] rd_data;
    logic [6:0] level;
    logic       hi_alert, lo_alert, ovfl_err, irq;
    logic [1:0] irq_pend;

    int vec = 0;
    int miss = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shared_fifo_alert dut (
        .clk(clk), .rst(rst), .eng_active(eng_active),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_wdata(eng_wdata),
        .flush(flush), .water(water), .irq_en(irq_en), .irq_ack(irq_ack),
        .rd_data(rd_data), .level(level), .hi_alert(hi_alert),
        .lo_alert(lo_alert), .ovfl_err(ovfl_err), .irq_pend(irq_pend), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic pop_exp(input string req, input int exp);
        host_rd = 1'b1;
        #1;
        chk(req, int'(rd_data), exp);
        tick();
        host_rd = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    function automatic int exp_hi(input int n, input int w);
        return ((64 - n) <= w) ? 1 : 0;
    endfunction

    function automatic int exp_lo(input int n, input int w);
        return (n <= w) ? 1 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R12 reset state
        chk("R12 level", int'(level), 0);
        chk("R12 ovfl", int'(ovfl_err), 0);
        chk("R4 rd_data empty", int'(rd_data), 0);
        chk("R7 lo after reset", int'(lo_alert), 1);
        chk("R6 hi after reset", int'(hi_alert), 0);
        repeat (2) tick();
        chk("R12 no pending", int'(irq_pend), 0);
        chk("R12 irq low", int'(irq), 0);

        // Sweep every water level: fill, overflow, drain (R1 R2 R3 R4 R6 R7)
        irq_en = 2'b00;
        for (int w = 0; w <= 64; w++) begin
            water = 7'(w);
            do_flush();
            chk("R5 flush level", int'(level), 0);
            chk("R5 flush ovfl", int'(ovfl_err), 0);
            for (int n = 0; n < 64; n++) begin
                push(8'((n * 7 + w) & 255));
                chk("R1 level fill", int'(level), n + 1);
                chk("R6 hi fill", int'(hi_alert), exp_hi(n + 1, w));
                chk("R7 lo fill", int'(lo_alert), exp_lo(n + 1, w));
            end
            push(8'hEE);
            chk("R3 ovfl set", int'(ovfl_err), 1);
            chk("R3 level held", int'(level), 64);
            for (int n = 0; n < 64; n++) begin
                pop_exp("R2 order", (n * 7 + w) & 255);
                chk("R2 level drain", int'(level), 63 - n);
                chk("R6 hi drain", int'(hi_alert), exp_hi(63 - n, w));
                chk("R7 lo drain", int'(lo_alert), exp_lo(63 - n, w));
            end
            pop_exp("R4 empty read", 0);
            chk("R4 empty level", int'(level), 0);
            chk("R3 ovfl sticky", int'(ovfl_err), 1);
        end
        do_flush();
        chk("R5 ovfl cleared", int'(ovfl_err), 0);

        // R5 flush wins over push
        host_wr = 1'b1; host_wdata = 8'h5A; flush = 1'b1;
        tick();
        host_wr = 1'b0; flush = 1'b0;
        chk("R5 flush priority", int'(level), 0);

        // R10 side selection
        eng_active = 1'b1;
        push(8'hAA);
        chk("R10 host push ignored", int'(level), 0);
        eng_wr = 1'b1; eng_wdata = 8'h11; tick();
        eng_wdata = 8'h22; tick();
        eng_wr = 1'b0;
        chk("R10 engine push", int'(level), 2);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
        chk("R10 host pop ignored", int'(level), 2);
        eng_rd = 1'b1; #1;
        chk("R10 engine read data", int'(rd_data), 8'h11);
        tick(); eng_rd = 1'b0;
        chk("R10 engine pop", int'(level), 1);
        eng_active = 1'b0;
        eng_wr = 1'b1; eng_wdata = 8'h77; tick(); eng_wr = 1'b0;
        chk("R10 engine push ignored", int'(level), 1);
        pop_exp("R10 host read", 8'h22);

        // R11 simultaneous push and pop
        host_wr = 1'b1; host_rd = 1'b1; host_wdata = 8'h33;
        tick();
        host_wr = 1'b0; host_rd = 1'b0;
        chk("R11 empty pushpop level", int'(level), 1);
        host_wr = 1'b1; host_rd = 1'b1; host_wdata = 8'h44; #1;
        chk("R11 pushpop data", int'(rd_data), 8'h33);
        tick();
        host_wr = 1'b0; host_rd = 1'b0;
        chk("R11 pushpop level", int'(level), 1);
        pop_exp("R11 next byte", 8'h44);
        for (int n = 0; n < 64; n++) push(8'(n));
        host_wr = 1'b1; host_rd = 1'b1; host_wdata = 8'hFF;
        tick();
        host_wr = 1'b0; host_rd = 1'b0;
        chk("R11 full pushpop level", int'(level), 63);
        chk("R11 full pushpop ovfl", int'(ovfl_err), 1);
        pop_exp("R11 full pushpop order", 1);

        // R8 R9 interrupts, water 4
        water = 7'd4;
        do_flush();
        irq_ack = 2'b11; tick(); irq_ack = 2'b00;
        chk("R9 ack all", int'(irq_pend), 0);
        irq_en = 2'b01;
        for (int n = 0; n < 5; n++) push(8'(n));
        chk("R8 no pend on fall", int'(irq_pend), 0);
        pop_exp("R8 pop", 0);
        chk("R8 pend not yet", int'(irq_pend), 0);
        tick();
        chk("R8 lo pend", int'(irq_pend), 1);
        chk("R8 irq", int'(irq), 1);
        irq_ack = 2'b01; tick(); irq_ack = 2'b00;
        chk("R9 lo ack", int'(irq_pend), 0);
        chk("R9 irq low", int'(irq), 0);
        irq_en = 2'b10;
        for (int n = 0; n < 55; n++) push(8'(n));
        chk("R8 level 59", int'(level), 59);
        chk("R8 hi not pend", int'(irq_pend), 0);
        push(8'h99);
        irq_ack = 2'b10;
        tick();
        irq_ack = 2'b00;
        chk("R9 set wins over ack", int'(irq_pend), 2);
        irq_ack = 2'b10; tick(); irq_ack = 2'b00;
        chk("R9 hi ack", int'(irq_pend), 0);
        irq_en = 2'b00;
        do_flush();
        for (int n = 0; n < 5; n++) push(8'(n));
        pop_exp("R8 pop disabled", 0);
        repeat (2) tick();
        chk("R8 disabled no pend", int'(irq_pend), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule